// File: doc/BRIEF.md
# Processor Flag Register with Interrupt Channel Assignment

This block keeps four processor error flags (power failure, memory parity error, access to nonexistent memory, and a software-requested flag), an enable bit for each flag, and a 3-bit field that assigns the flags to one of seven priority interrupt channels. Software changes this state through a single command write. One write can set, clear, enable or disable each flag, reload the channel assignment, and issue one combined clear. The state reads back on a status word at all times.

Hardware monitors report events as one-cycle pulses, and each pulse sets its flag. When at least one flag is both set and enabled, and the channel assignment is nonzero, the block raises exactly one bit of a 7-bit request vector to the priority interrupt controller. The combined clear command also emits a one-cycle I/O-reset pulse for the peripheral bus. The priority arbitration happens in the interrupt controller, outside this block.

Top module: `flagreg_top`

## Requirements
- R1: Every accepted write (cmd_we high) loads cmd_data[2:0] into the channel assignment. The new value appears on sts_data[2:0] after that clock edge.
- R2: A write with cmd_data[2:0] equal to zero clears the assignment. While the assignment is zero, irq_req is all zeros, whatever the flags hold.
- R3: In a write, cmd_data[3+i] sets flag i (0 power fail, 1 parity, 2 nonexistent memory, 3 software). A set flag shows on sts_data[3+i] and stays set through idle cycles until something clears it.
- R4: In a write, cmd_data[7+i] clears flag i. If the same write also sets flag i, the clear wins.
- R5: In a write, cmd_data[11+i] enables flag i and cmd_data[15+i] disables it, and disable wins over enable in the same write. The enables read back on sts_data[10:7].
- R6: irq_req[c-1] is high exactly when the assignment equals c (from 1 to 7) and some flag is both set and enabled. No more than one bit of irq_req is ever high. The output follows the registered state with no extra delay.
- R7: A flag that is set while its enable is off raises no request on any channel.
- R8: A write with cmd_data[19] set clears all four flags and leaves the enables unchanged. io_reset is high for exactly the one cycle after that edge.
- R9: A high ev_pulse[i] sets flag i at the clock edge, with or without a write. In the same cycle it wins over a command clear of that flag.
- R10: After reset, the assignment, flags and enables are zero, and irq_req and io_reset are low.
- R11: While cmd_we is low, cmd_data has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 20 | Command word: assignment, per-flag set/clear/enable/disable, combined clear |
| ev_pulse | input | 4 | One-cycle event pulses from the error monitors |
| sts_data | output | 11 | Status word: assignment, flags, enables |
| irq_req | output | 7 | Request to the interrupt controller, one bit per channel |
| io_reset | output | 1 | One-cycle I/O-reset pulse |

## Verification
Every piece of state has a direct image at the ports. A wrong assignment, flag or enable shows on sts_data on the first sample after the offending edge. A wrong combination of them shows on irq_req in that same cycle, because the request is decoded combinationally from the registers. The bench therefore compares the full status, request and I/O-reset values in every cycle it drives. It targets the same-write conflicts (set against clear, enable against disable, event against clear), assignment zero with an active flag, and a sweep of all seven channels. Any one-cycle error in the I/O-reset pulse, in either direction, appears at the sample taken right after the combined clear, or at the sample one cycle later.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

    localparam int NFLAG      = 4;
    localparam int CHAN_W     = 3;
    localparam int NCHAN      = (1 << CHAN_W) - 1;
    localparam int SET_LSB    = CHAN_W;
    localparam int CLR_LSB    = SET_LSB + NFLAG;
    localparam int ENA_LSB    = CLR_LSB + NFLAG;
    localparam int DIS_LSB    = ENA_LSB + NFLAG;
    localparam int ALLCLR_BIT = DIS_LSB + NFLAG;
    localparam int CMD_W      = ALLCLR_BIT + 1;
    localparam int STS_W      = CHAN_W + 2 * NFLAG;

    typedef struct packed {
        logic              load;
        logic [CHAN_W-1:0] chan;
        logic [NFLAG-1:0]  set;
        logic [NFLAG-1:0]  clr;
        logic [NFLAG-1:0]  ena;
        logic [NFLAG-1:0]  dis;
        logic              all_clr;
    } cmd_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [NFLAG-1:0]  flag;
        logic [NFLAG-1:0]  en;
        logic              io_rst;
    } state_t;

endpackage

// File: rtl/flagreg_cmd_decode.sv
module flagreg_cmd_decode
    import flagreg_pkg::*;
(
    input  logic             we,
    input  logic [CMD_W-1:0] data,
    output cmd_t             cmd
);

    // Any field is qualified by the write strobe, so an idle bus cannot act.
    always_comb begin
        cmd         = '0;
        cmd.load    = we;
        if (we) begin
            cmd.chan    = data[CHAN_W-1:0];
            cmd.set     = data[SET_LSB +: NFLAG];
            cmd.clr     = data[CLR_LSB +: NFLAG];
            cmd.ena     = data[ENA_LSB +: NFLAG];
            cmd.dis     = data[DIS_LSB +: NFLAG];
            cmd.all_clr = data[ALLCLR_BIT];
        end
    end

endmodule

// File: rtl/flagreg_store.sv
module flagreg_store
    import flagreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic [NFLAG-1:0] ev,
    output state_t           st
);

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.io_rst = cmd.load & cmd.all_clr;
        if (cmd.load) begin
            st_d.chan = cmd.chan;
            st_d.en   = (st_q.en | cmd.ena) & ~cmd.dis;
        end
        for (int i = 0; i < NFLAG; i++) begin
            logic nf;
            nf = st_q.flag[i];
            if (cmd.set[i]) nf = 1'b1;
            if (cmd.clr[i] || cmd.all_clr) nf = 1'b0;
            if (ev[i]) nf = 1'b1;
            st_d.flag[i] = nf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    p_assign_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.load |=> st_q.chan == $past(cmd.chan));

    p_io_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.load && cmd.all_clr) |=> st_q.io_rst);

    p_io_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.io_rst |=> !st_q.io_rst || $past(cmd.load && cmd.all_clr));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.load && ev == '0) |=> $stable(st_q.chan) && $stable(st_q.flag) && $stable(st_q.en));

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag_chk
        p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.load && cmd.clr[g] && !ev[g]) |=> !st_q.flag[g]);
        p_disable_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.load && cmd.dis[g]) |=> !st_q.en[g]);
        p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ev[g] |=> st_q.flag[g]);
    end

endmodule

// File: rtl/flagreg_chan_route.sv
module flagreg_chan_route
    import flagreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] chan,
    input  logic [NFLAG-1:0]  flag,
    input  logic [NFLAG-1:0]  en,
    output logic [NCHAN-1:0]  req
);

    logic active;
    assign active = |(flag & en);

    for (genvar c = 1; c <= NCHAN; c++) begin : g_chan
        assign req[c-1] = active && (chan == CHAN_W'(c));
    end

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    p_zero_assign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan == '0) |-> (req == '0));

    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & en) == '0) |-> (req == '0));

endmodule

// File: rtl/flagreg_top.sv
module flagreg_top
    import flagreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic [NFLAG-1:0] ev_pulse,
    output logic [STS_W-1:0] sts_data,
    output logic [NCHAN-1:0] irq_req,
    output logic             io_reset
);

    cmd_t   cmd;
    state_t st;

    flagreg_cmd_decode u_dec (
        .we   (cmd_we),
        .data (cmd_data),
        .cmd  (cmd)
    );

    flagreg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ev    (ev_pulse),
        .st    (st)
    );

    flagreg_chan_route u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .chan  (st.chan),
        .flag  (st.flag),
        .en    (st.en),
        .req   (irq_req)
    );

    assign sts_data = {st.en, st.flag, st.chan};
    assign io_reset = st.io_rst;

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0 && !io_reset));

endmodule

// File: tb/flagreg_top_tb.sv
module flagreg_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [19:0] cmd_data = '0;
    logic [3:0]  ev_pulse = '0;
    logic [10:0] sts_data;
    logic [6:0]  irq_req;
    logic        io_reset;

    always #5 clk = ~clk;

    flagreg_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .ev_pulse (ev_pulse),
        .sts_data (sts_data),
        .irq_req  (irq_req),
        .io_reset (io_reset)
    );

    typedef struct {
        int          due;
        logic [10:0] sts;
        logic [6:0]  irq;
        logic        io;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 0;

    logic [2:0] m_chan = '0;
    logic [3:0] m_flag = '0;
    logic [3:0] m_en   = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [19:0] mk(input logic [2:0] ch, input logic [3:0] s,
                                       input logic [3:0] c, input logic [3:0] e,
                                       input logic [3:0] d, input logic a);
        return {a, d, e, c, s, ch};
    endfunction

    function automatic logic [6:0] m_irq();
        logic [6:0] r = '0;
        if (m_chan != 3'd0 && (m_flag & m_en) != 4'd0) r[m_chan - 3'd1] = 1'b1;
        return r;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic we, input logic [19:0] d, input logic [3:0] ev, input string tag);
        exp_t it;
        @(negedge clk);
        cmd_we   = we;
        cmd_data = d;
        ev_pulse = ev;
        if (we) begin
            m_chan = d[2:0];
            m_en   = (m_en | d[14:11]) & ~d[18:15];
            m_flag = (m_flag | d[6:3]) & ~d[10:7];
            if (d[19]) m_flag = '0;
        end
        m_flag = m_flag | ev;
        it.due = cyc + 1;
        it.sts = {m_en, m_flag, m_chan};
        it.irq = m_irq();
        it.io  = we & d[19];
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares at the falling edge after the edge that produced the result.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (sts_data !== it.sts || irq_req !== it.irq || io_reset !== it.io) begin
                n_bad++;
                $display("FAIL %s: sts=%h irq=%b io=%b expected sts=%h irq=%b io=%b",
                         it.tag, sts_data, irq_req, io_reset, it.sts, it.irq, it.io);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (sts_data !== '0 || irq_req !== '0 || io_reset !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: sts=%h irq=%b io=%b expected all zero", sts_data, irq_req, io_reset);
        end
        rst_n = 1'b1;

        step(1, mk(3'd5, 0, 0, 0, 0, 0), 4'd0, "R1 assignment load");
        step(1, mk(3'd3, 4'b0010, 0, 0, 0, 0), 4'd0, "R7 set flag, enable off");
        step(0, 20'hFFFFF, 4'd0, "R11 data ignored without strobe");
        step(0, '0, 4'd0, "R3 flag held idle");
        step(1, mk(3'd3, 0, 0, 4'b0010, 0, 0), 4'd0, "R6 enable raises channel 3");
        step(1, mk(3'd3, 4'b0010, 4'b0010, 0, 0, 0), 4'd0, "R4 clear wins over set");
        step(1, mk(3'd7, 4'b0100, 0, 4'b0100, 4'b0100, 0), 4'd0, "R5 disable wins over enable");
        step(1, mk(3'd7, 0, 0, 4'b0100, 0, 0), 4'd0, "R5 enable alone");
        step(1, mk(3'd0, 0, 0, 0, 0, 0), 4'd0, "R2 zero assignment drops request");
        step(1, mk(3'd1, 0, 4'b1000, 4'b1000, 0, 0), 4'b1000, "R9 event beats clear");
        step(0, '0, 4'b0001, "R9 event without write");
        step(1, mk(3'd6, 0, 0, 0, 0, 1), 4'd0, "R8 combined clear");
        step(0, '0, 4'd0, "R8 io reset ends");
        step(1, mk(3'd6, 4'b1111, 0, 0, 0, 0), 4'd0, "R3 set all flags");
        for (int c = 1; c <= 7; c++) step(1, mk(3'(c), 0, 0, 0, 0, 0), 4'd0, "R6 channel sweep");
        step(1, mk(3'd2, 0, 0, 0, 4'b1111, 0), 4'd0, "R7 all disabled");
        step(1, mk(3'd0, 0, 0, 4'b1111, 0, 0), 4'd0, "R2 zero assignment with active flags");
        step(1, mk(3'd4, 0, 0, 0, 0, 1), 4'b0100, "R9 event during combined clear");
        step(0, '0, 4'd0, "R8 pulse single cycle");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule